// File: doc/BRIEF.md
# Three-Wire Serial Configuration Slave

This block is a write-only configuration port. An external controller drives three pins: a serial clock, a serial data line and a mode line. The block samples them into the system clock domain through a two-flop stage and assembles bytes from them. Bits arrive least significant first on each rising serial clock edge.

While the mode line is low, a completed byte is an address byte. Its upper six bits must equal the device address 000101 for the port to become selected. Its lower two bits pick the register bank that later bytes will write. While the mode line is high, completed bytes are data bytes for the bank that was last selected. Bits 7:6 of a data byte pick a field within the bank, and bits 5:0 carry the value.

The decoded fields drive the rest of the chip directly as plain level outputs:
- system clock ratio select
- serial audio input format
- volume attenuation code
- de-emphasis select
- mute

Top module: `sc_ctl_slave`

## Requirements
- R1: An address byte whose bits 7:2 equal 000101 selects the port. Any other address byte deselects it. While deselected, data bytes change no output until a matching address byte arrives.
- R2: Address bits 1:0 choose the bank: 00 is the audio bank and 10 is the format bank. Codes 01 and 11 leave the port selected, but data bytes then write nothing.
- R3: Once selected, a bank accepts any number of consecutive data bytes without a new address byte.
- R4: Only a complete 8-bit byte has an effect. Any transition of the mode line clears the bit count, so a partial byte is discarded and the next byte is framed from the following bit.
- R5: Bits are taken least significant first on rising serial clock edges. Mode line low marks an address byte and high marks a data byte.
- R6: In the format bank, selector 00 writes the clock select from bits 5:4 and the input format from bits 3:1. Clock select encoding: 00 = 512x, 01 = 384x, 10 = 256x. Format encoding: 000 = I2S, 001/010/011 = right-justified 16/18/20 bit, 100 = left-justified. The other selectors in this bank are ignored.
- R7: In the audio bank, selector 00 writes the 6-bit volume code from bits 5:0.
- R8: In the audio bank, selector 10 writes de-emphasis from bits 4:3 and mute from bit 2.
- R9: In the audio bank, selector 11 with value 000001 returns every field to its reset value. Selector 11 with any other value is ignored, and so is selector 01.
- R10: After reset the outputs are volume 0, mute 0, de-emphasis 00, clock select 10 and format 000, and no bank is selected.
- R11: The outputs change only right after a completed byte. They hold still while a byte is being shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Serial clock, asynchronous to clk |
| ctl_data | input | 1 | Serial data, LSB first |
| ctl_mode | input | 1 | Low = address byte, high = data byte |
| clk_sel | output | 2 | System clock ratio select |
| fmt_sel | output | 3 | Serial audio input format |
| vol_code | output | 6 | Volume attenuation code |
| deemph | output | 2 | De-emphasis select |
| mute | output | 1 | Mute enable |

## Verification
The hardest case to reach from the pins is a byte abandoned part-way. This needs serial clock edges to stop at a non-zero bit count while the mode line toggles, and then a fresh byte must frame correctly. The bench shifts in seven bits and checks that the outputs have not moved. It then pulses the mode line low and high without any clock edges, sends a full byte, and expects exactly that byte's value. Deselection is reached through a mismatching address byte followed by data. Re-selection is then checked with a correct address byte.

// File: rtl/sc_ctl_pkg.sv
package sc_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_ADDR = 6'b000101;

  typedef enum logic [1:0] {
    XT_AUDIO  = 2'b00,
    XT_RSVD1  = 2'b01,
    XT_FORMAT = 2'b10,
    XT_RSVD3  = 2'b11
  } xfer_t;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic [2:0] fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{clk_sel: 2'b10, fmt: 3'b000, vol: 6'd0,
                                   deemph: 2'b00, mute: 1'b0};
  localparam logic [5:0] RESTORE_KEY = 6'b000001;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sc_shifter.sv
module sc_shifter #(
  parameter int BW = sc_ctl_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_clk,
  input  logic          s_data,
  input  logic          s_mode,
  output logic          byte_vld,
  output logic [BW-1:0] byte_q,
  output logic          byte_is_data
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic          clk_d, mode_d;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;
  logic          rise, mode_chg;

  assign rise     = s_clk & ~clk_d;
  assign mode_chg = s_mode ^ mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d        <= 1'b0;
      mode_d       <= 1'b0;
      cnt          <= '0;
      sh           <= '0;
      byte_vld     <= 1'b0;
      byte_q       <= '0;
      byte_is_data <= 1'b0;
    end else begin
      clk_d    <= s_clk;
      mode_d   <= s_mode;
      byte_vld <= 1'b0;
      if (mode_chg) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= {s_data, sh[BW-1:1]};
        if (cnt == LAST) begin
          cnt          <= '0;
          byte_vld     <= 1'b1;
          byte_q       <= {s_data, sh[BW-1:1]};
          byte_is_data <= s_mode;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt == '0));
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
  import sc_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_q,
  input  logic        byte_is_data,
  output cfg_t        cfg
);
  logic  sel_q;
  xfer_t xfer_q;
  cfg_t  cfg_q;
  logic  addr_hit;
  logic [1:0] sub;
  logic [5:0] val;

  assign addr_hit = (byte_q[7:2] == DEV_ADDR);
  assign sub      = byte_q[7:6];
  assign val      = byte_q[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      xfer_q <= XT_AUDIO;
      cfg_q  <= CFG_DEFAULT;
    end else if (byte_vld) begin
      if (!byte_is_data) begin
        sel_q  <= addr_hit;
        xfer_q <= xfer_t'(byte_q[1:0]);
      end else if (sel_q) begin
        case (xfer_q)
          XT_FORMAT: begin
            if (sub == 2'b00) begin
              cfg_q.clk_sel <= val[5:4];
              cfg_q.fmt     <= val[3:1];
            end
          end
          XT_AUDIO: begin
            case (sub)
              2'b00: cfg_q.vol <= val;
              2'b10: begin
                cfg_q.deemph <= val[4:3];
                cfg_q.mute   <= val[2];
              end
              2'b11: if (val == RESTORE_KEY) cfg_q <= CFG_DEFAULT;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg = cfg_q;

  p_mismatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_is_data && (byte_q[7:2] != DEV_ADDR)) |=> !sel_q);
  p_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_is_data && !sel_q) |=> $stable(cfg_q));
  p_format_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_is_data && xfer_q == XT_FORMAT)
      |=> $stable({cfg_q.vol, cfg_q.deemph, cfg_q.mute}));
  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_is_data && sel_q && xfer_q == XT_AUDIO && byte_q == 8'hC1)
      |=> (cfg_q == CFG_DEFAULT));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(cfg_q));
endmodule

// File: rtl/sc_ctl_slave.sv
module sc_ctl_slave
  import sc_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_clk,
  input  logic       ctl_data,
  input  logic       ctl_mode,
  output logic [1:0] clk_sel,
  output logic [2:0] fmt_sel,
  output logic [5:0] vol_code,
  output logic [1:0] deemph,
  output logic       mute
);
  logic [2:0]        pins_s;
  logic              byte_vld, byte_is_data;
  logic [BYTE_W-1:0] byte_q;
  cfg_t              cfg;

  sc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ctl_mode, ctl_data, ctl_clk}),
    .q     (pins_s)
  );

  sc_shifter #(.BW(BYTE_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_clk        (pins_s[0]),
    .s_data       (pins_s[1]),
    .s_mode       (pins_s[2]),
    .byte_vld     (byte_vld),
    .byte_q       (byte_q),
    .byte_is_data (byte_is_data)
  );

  sc_regbank u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_q       (byte_q),
    .byte_is_data (byte_is_data),
    .cfg          (cfg)
  );

  assign clk_sel  = cfg.clk_sel;
  assign fmt_sel  = cfg.fmt;
  assign vol_code = cfg.vol;
  assign deemph   = cfg.deemph;
  assign mute     = cfg.mute;
endmodule

// File: tb/test_sc_ctl_slave.sv
module test_sc_ctl_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b0, ctl_data = 1'b0, ctl_mode = 1'b0;
  logic [1:0] clk_sel;
  logic [2:0] fmt_sel;
  logic [5:0] vol_code;
  logic [1:0] deemph;
  logic       mute;

  int n_chk = 0;
  int n_bad = 0;
  localparam int HALF = 6;

  always #2.5 clk = ~clk;

  sc_ctl_slave i_sc_ctl_slave (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_data(ctl_data),
    .ctl_mode(ctl_mode), .clk_sel(clk_sel), .fmt_sel(fmt_sel),
    .vol_code(vol_code), .deemph(deemph), .mute(mute)
  );

  // expected word: {clk_sel[2], fmt[3], vol[6], deemph[2], mute[1]}
  function automatic logic [13:0] outs();
    return {clk_sel, fmt_sel, vol_code, deemph, mute};
  endfunction

  // vector: {address byte, data byte, expected outputs afterwards}
  localparam logic [29:0] VEC [12] = '{
    {8'h14, 8'h05, 2'b10, 3'b000, 6'd5,  2'b00, 1'b0}, // R7 volume
    {8'h16, 8'h1A, 2'b01, 3'b101, 6'd5,  2'b00, 1'b0}, // R6 clock and format
    {8'h14, 8'h94, 2'b01, 3'b101, 6'd5,  2'b10, 1'b1}, // R8 de-emphasis, mute
    {8'h15, 8'h3F, 2'b01, 3'b101, 6'd5,  2'b10, 1'b1}, // R2 unused bank 01
    {8'h54, 8'h3F, 2'b01, 3'b101, 6'd5,  2'b10, 1'b1}, // R1 wrong address
    {8'h16, 8'h80, 2'b01, 3'b101, 6'd5,  2'b10, 1'b1}, // R6 other selector ignored
    {8'h14, 8'h41, 2'b01, 3'b101, 6'd5,  2'b10, 1'b1}, // R9 selector 01 ignored
    {8'h14, 8'hC2, 2'b01, 3'b101, 6'd5,  2'b10, 1'b1}, // R9 wrong restore value
    {8'h14, 8'hC1, 2'b10, 3'b000, 6'd0,  2'b00, 1'b0}, // R9 restore defaults
    {8'h16, 8'h36, 2'b11, 3'b011, 6'd0,  2'b00, 1'b0}, // R6 second pattern
    {8'h17, 8'h00, 2'b11, 3'b011, 6'd0,  2'b00, 1'b0}, // R2 unused bank 11
    {8'h14, 8'h3F, 2'b11, 3'b011, 6'd63, 2'b00, 1'b0}  // R7 full scale code
  };

  function automatic string vec_req(int i);
    case (i)
      0, 11: return "R7";
      1, 5, 9: return "R6";
      2: return "R8";
      3, 10: return "R2";
      4: return "R1";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [13:0] act, logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic mode, logic [7:0] b, int n);
    @(negedge clk);
    ctl_mode = mode;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ctl_data = b[i];
      repeat (HALF) @(negedge clk);
      ctl_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ctl_clk = 1'b0;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic send_byte(logic mode, logic [7:0] b);
    send_bits(mode, b, 8);
  endtask

  localparam logic [13:0] DEF = {2'b10, 3'b000, 6'd0, 2'b00, 1'b0};

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 reset values", outs(), DEF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      send_byte(1'b0, VEC[i][29:22]);
      send_byte(1'b1, VEC[i][21:14]);
      check(vec_req(i), outs(), VEC[i][13:0]);
    end

    // R3: multiple data bytes after one address byte
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h07);
    send_byte(1'b1, 8'h90);
    check("R3 persistent bank", outs(), {2'b11, 3'b011, 6'd7, 2'b10, 1'b0});

    // R5: LSB first, 0x01 sets volume 1
    send_byte(1'b1, 8'h01);
    check("R5 bit order", outs(), {2'b11, 3'b011, 6'd1, 2'b10, 1'b0});

    // R11: seven bits shifted, nothing moves
    send_bits(1'b1, 8'h2A, 7);
    check("R11 mid-byte hold", outs(), {2'b11, 3'b011, 6'd1, 2'b10, 1'b0});

    // R4: mode pulse discards the partial byte
    @(negedge clk); ctl_mode = 1'b0;
    repeat (8) @(negedge clk); ctl_mode = 1'b1;
    repeat (8) @(negedge clk);
    send_byte(1'b1, 8'h09);
    check("R4 reframe after mode toggle", outs(), {2'b11, 3'b011, 6'd9, 2'b10, 1'b0});

    // R1: deselect then reselect
    send_byte(1'b0, 8'h50);
    send_byte(1'b1, 8'h11);
    check("R1 deselected ignores data", outs(), {2'b11, 3'b011, 6'd9, 2'b10, 1'b0});
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h11);
    check("R1 reselected writes", outs(), {2'b11, 3'b011, 6'd17, 2'b10, 1'b0});

    // R10: reset mid-run, then no bank selected
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset mid-run", outs(), DEF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(1'b1, 8'h22);
    check("R10 no bank after reset", outs(), DEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule